// File: doc/BRIEF.md
# Rotating Register File with Renaming Base

This block holds the general registers and the one-bit predicates for a core that runs software-pipelined loops. Its general file has two halves. The static half is addressed directly. The rotating half is addressed through a base pointer: the logical index is added to the base, modulo the size of the half, to find the physical entry. A loop-closing branch pulses the rotate input. That pulse steps the base down by one, so each value in the rotating half is named one index higher afterwards. A pipelined loop kernel can therefore reuse the same register names on every iteration without unrolling.

The predicate file rotates on the same pulse, using its own base of the same kind. After one rotate, predicate 1 holds what predicate 0 held before it, and predicate 0 holds what the highest predicate held. Predicates can be read and written one bit at a time. They can also be read and written as one aggregate word, in which bit i is logical predicate i.

The block has two combinational read ports and one write port on the general file. Writes take effect at the clock edge. Any write that lands in the same cycle as a rotate is placed using the mapping that was in force before that rotate.

Top module: `rot_regfile`

## Requirements
- R1: Reset sets both bases to zero and clears every predicate, so the aggregate predicate read returns 0. General register contents are not cleared. After reset, rotating logical index i addresses physical rotating entry i.
- R2: A logical index with its top bit (bit 5 by default) clear selects the static entry named by the lower bits. A value written there is read back unchanged at that index, whatever rotates happen.
- R3: A logical index with its top bit set selects the rotating entry at (base + low bits) mod 32. With no rotate in between, a value written at a logical index reads back at the same index.
- R4: A rotate pulse lowers the base by one, wrapping from 0 to 31. A value named rotating index i is then named i+1 (mod 32), and after 32 rotates it has its original name again.
- R5: A general write in the same cycle as a rotate uses the pre-rotate mapping. The value written at logical i is read at logical i+1 after that edge.
- R6: The reads are combinational and the two ports are independent. Reading the index that is being written in the same cycle returns the old value; the new value appears after the clock edge.
- R7: On a rotate, logical predicate i+1 takes the old value of logical predicate i, and logical predicate 0 takes the old value of logical predicate 31. Without a rotate or a write, the predicates hold their values.
- R8: The aggregate write sets logical predicate i from bit i of the word. The aggregate read returns logical predicate i in bit i, and the single-bit read at index i returns the same value.
- R9: When a single-bit predicate write and an aggregate write happen in the same cycle, the single-bit write wins for its own index. A single-bit write in a rotate cycle uses the pre-rotate mapping.
- R10: An aggregate write in a rotate cycle uses the pre-rotate mapping. The aggregate read afterwards returns the written word rotated left by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_idx | input | 6 | Logical index for read port 0 |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_idx | input | 6 | Logical index for read port 1 |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 6 | Logical index for the write |
| wr_data | input | 32 | Write data |
| rotate | input | 1 | Loop-branch strobe that steps both bases |
| pred_rd_idx | input | 5 | Logical predicate index to read |
| pred_rd_bit | output | 1 | Value of the selected predicate |
| pred_wr_en | input | 1 | Single predicate write enable |
| pred_wr_idx | input | 5 | Logical predicate index to write |
| pred_wr_bit | input | 1 | Predicate value to write |
| pagg_wr_en | input | 1 | Aggregate predicate write enable |
| pagg_wr_data | input | 32 | Aggregate predicate word, bit i is logical predicate i |
| pagg_rd_data | output | 32 | All predicates in logical order |

## Verification
The bench builds the block with its default parameters: 32 static and 32 rotating 32-bit registers, and 32 predicates. With these sizes, a short run reaches the wrap of the base from 0 to 31. It also reaches the wrap of logical index 31 to index 0 on both files, and a full cycle of 32 rotates that brings a value back to its original name. The stimulus table checks the renaming through writes, rotates and writes made in rotate cycles. Directed tests then cover the reset state, reads during a write, and the predicate cases: the top predicate wrapping into predicate 0, an aggregate write in a rotate cycle, and a single-bit write and an aggregate write colliding.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  // Slot reached by stepping 'step' places forward from 'start' on a ring of n entries.
  function automatic int unsigned ring_slot(int unsigned start, int unsigned step,
                                            int unsigned n);
    return (start + step) % n;
  endfunction

  // One step backwards on the ring, wrapping 0 to n-1.
  function automatic int unsigned ring_back(int unsigned cur, int unsigned n);
    return (cur == 0) ? n - 1 : cur - 1;
  endfunction

  // Logical name held by physical slot 'phys' when the ring base is 'base'.
  function automatic int unsigned ring_name(int unsigned phys, int unsigned base,
                                            int unsigned n);
    return (phys + n - base) % n;
  endfunction

endpackage

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int N = 32,
  localparam int BW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rotate,
  output logic [BW-1:0] base
);
  import rrf_pkg::*;

  logic [BW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base_q <= '0;
    else if (rotate)
      base_q <= BW'(ring_back(int'(base_q), N));
  end

  assign base = base_q;
endmodule

// File: rtl/rrf_gpr.sv
module rrf_gpr #(
  parameter int DW = 32,
  parameter int LW = 5,
  localparam int N  = 1 << LW,
  localparam int IW = LW + 1
) (
  input  logic          clk,
  input  logic [LW-1:0] base,
  input  logic [IW-1:0] rd0_idx,
  output logic [DW-1:0] rd0_data,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  import rrf_pkg::*;

  logic [DW-1:0] stat_q [N];
  logic [DW-1:0] rot_q  [N];

  // Physical rotating slot for the write, using the base before any rotate this cycle.
  logic [LW-1:0] wr_slot;
  logic          wr_rot;
  assign wr_rot  = wr_idx[IW-1];
  assign wr_slot = LW'(ring_slot(int'(base), int'(wr_idx[LW-1:0]), N));

  function automatic logic [DW-1:0] pick(input logic [IW-1:0] idx,
                                         input logic [LW-1:0] b);
    logic [LW-1:0] s;
    s = LW'(ring_slot(int'(b), int'(idx[LW-1:0]), N));
    return idx[IW-1] ? rot_q[s] : stat_q[idx[LW-1:0]];
  endfunction

  assign rd0_data = pick(rd0_idx, base);
  assign rd1_data = pick(rd1_idx, base);

  for (genvar e = 0; e < N; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && !wr_rot && wr_idx[LW-1:0] == LW'(e))
        stat_q[e] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_rot && wr_slot == LW'(e))
        rot_q[e] <= wr_data;
    end
  end
endmodule

// File: rtl/rrf_pred.sv
module rrf_pred #(
  parameter int LW = 5,
  localparam int N = 1 << LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] base,
  input  logic [LW-1:0] pred_rd_idx,
  output logic          pred_rd_bit,
  input  logic          pred_wr_en,
  input  logic [LW-1:0] pred_wr_idx,
  input  logic          pred_wr_bit,
  input  logic          pagg_wr_en,
  input  logic [N-1:0]  pagg_wr_data,
  output logic [N-1:0]  pagg_rd_data
);
  import rrf_pkg::*;

  logic [N-1:0] phys_q;

  for (genvar p = 0; p < N; p++) begin : g_bit
    logic [LW-1:0] name;
    logic          nxt;
    assign name = LW'(ring_name(p, int'(base), N));
    // A single-bit write overrides the aggregate word for its own index.
    always_comb begin
      nxt = phys_q[p];
      if (pagg_wr_en)
        nxt = pagg_wr_data[name];
      if (pred_wr_en && pred_wr_idx == name)
        nxt = pred_wr_bit;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        phys_q[p] <= 1'b0;
      else
        phys_q[p] <= nxt;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_view
    assign pagg_rd_data[i] = phys_q[LW'(ring_slot(int'(base), i, N))];
  end

  assign pred_rd_bit = pagg_rd_data[pred_rd_idx];
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int DATA_W  = 32,
  parameter int GPR_LW  = 5,
  parameter int PRED_LW = 5,
  localparam int IDX_W  = GPR_LW + 1,
  localparam int PRED_N = 1 << PRED_LW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd0_idx,
  output logic [DATA_W-1:0]  rd0_data,
  input  logic [IDX_W-1:0]   rd1_idx,
  output logic [DATA_W-1:0]  rd1_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rotate,
  input  logic [PRED_LW-1:0] pred_rd_idx,
  output logic               pred_rd_bit,
  input  logic               pred_wr_en,
  input  logic [PRED_LW-1:0] pred_wr_idx,
  input  logic               pred_wr_bit,
  input  logic               pagg_wr_en,
  input  logic [PRED_N-1:0]  pagg_wr_data,
  output logic [PRED_N-1:0]  pagg_rd_data
);

  // Named internal events, visible to the checker.
  logic [GPR_LW-1:0]  gpr_base;
  logic [PRED_LW-1:0] pred_base;

  rrf_base #(.N(1 << GPR_LW)) u_gpr_base (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .base(gpr_base)
  );

  rrf_base #(.N(PRED_N)) u_pred_base (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .base(pred_base)
  );

  rrf_gpr #(.DW(DATA_W), .LW(GPR_LW)) u_gpr (
    .clk(clk), .base(gpr_base),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  rrf_pred #(.LW(PRED_LW)) u_pred (
    .clk(clk), .rst_n(rst_n), .base(pred_base),
    .pred_rd_idx(pred_rd_idx), .pred_rd_bit(pred_rd_bit),
    .pred_wr_en(pred_wr_en), .pred_wr_idx(pred_wr_idx), .pred_wr_bit(pred_wr_bit),
    .pagg_wr_en(pagg_wr_en), .pagg_wr_data(pagg_wr_data), .pagg_rd_data(pagg_rd_data)
  );
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter int DATA_W  = 32,
  parameter int GPR_LW  = 5,
  parameter int PRED_LW = 5,
  localparam int IDX_W  = GPR_LW + 1,
  localparam int PRED_N = 1 << PRED_LW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rotate,
  input logic               wr_en,
  input logic               pred_wr_en,
  input logic               pagg_wr_en,
  input logic [IDX_W-1:0]   rd0_idx,
  input logic [DATA_W-1:0]  rd0_data,
  input logic [PRED_N-1:0]  pagg_rd_data,
  input logic [GPR_LW-1:0]  gpr_base,
  input logic [PRED_LW-1:0] pred_base
);

  assert_reset_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (gpr_base == '0 && pred_base == '0 && pagg_rd_data == '0));

  assert_base_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> ($past(gpr_base) == '0) ? (gpr_base == {GPR_LW{1'b1}})
                                        : (gpr_base == $past(gpr_base) - 1'b1));

  assert_pred_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !pagg_wr_en && !pred_wr_en) |=>
      pagg_rd_data == (($past(pagg_rd_data) << 1) | ($past(pagg_rd_data) >> (PRED_N - 1))));

  assert_pred_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !pagg_wr_en && !pred_wr_en) |=> $stable(pagg_rd_data));

  assert_static_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !wr_en && !rd0_idx[IDX_W-1] && !$isunknown(rd0_data)) |=>
      ($stable(rd0_idx) -> $stable(rd0_data)));

  assert_rename_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !wr_en && rd0_idx[IDX_W-1] && !$isunknown(rd0_data)) |=>
      ((rd0_idx[IDX_W-1] && rd0_idx[GPR_LW-1:0] == $past(rd0_idx[GPR_LW-1:0]) + 1'b1)
        -> rd0_data == $past(rd0_data)));
endmodule

bind rot_regfile rot_regfile_chk #(
  .DATA_W(DATA_W), .GPR_LW(GPR_LW), .PRED_LW(PRED_LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rotate(rotate), .wr_en(wr_en),
  .pred_wr_en(pred_wr_en), .pagg_wr_en(pagg_wr_en),
  .rd0_idx(rd0_idx), .rd0_data(rd0_data), .pagg_rd_data(pagg_rd_data),
  .gpr_base(gpr_base), .pred_base(pred_base)
);

// File: tb/rot_regfile_test.sv
module rot_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd0_idx = 6'd3, rd1_idx = 6'd3, wr_idx = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0, rotate = 1'b0;
  logic [4:0]  pred_rd_idx = '0, pred_wr_idx = '0;
  logic        pred_rd_bit, pred_wr_en = 1'b0, pred_wr_bit = 1'b0;
  logic        pagg_wr_en = 1'b0;
  logic [31:0] pagg_wr_data = '0, pagg_rd_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rot_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rotate(rotate),
    .pred_rd_idx(pred_rd_idx), .pred_rd_bit(pred_rd_bit),
    .pred_wr_en(pred_wr_en), .pred_wr_idx(pred_wr_idx), .pred_wr_bit(pred_wr_bit),
    .pagg_wr_en(pagg_wr_en), .pagg_wr_data(pagg_wr_data), .pagg_rd_data(pagg_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Let one clock edge pass, then drop every strobe.
  task automatic edge_then_idle();
    @(posedge clk);
    #1;
    wr_en = 1'b0; rotate = 1'b0; pred_wr_en = 1'b0; pagg_wr_en = 1'b0;
    #3;
  endtask

  // Vector fields: we, widx[6], wdata[32], rot, ridx[6], expected[32].
  localparam int NV = 8;
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 6'd3,  32'hA000_0003, 1'b0, 6'd3,  32'hA000_0003}, // R2 static write
    {1'b1, 6'd34, 32'hB000_0002, 1'b0, 6'd34, 32'hB000_0002}, // R3 rotating write
    {1'b0, 6'd0,  32'h0,         1'b1, 6'd35, 32'hB000_0002}, // R4 renamed to i+1
    {1'b0, 6'd0,  32'h0,         1'b0, 6'd3,  32'hA000_0003}, // R2 static unmoved
    {1'b1, 6'd34, 32'hC000_0034, 1'b1, 6'd35, 32'hC000_0034}, // R5 write with rotate
    {1'b1, 6'd63, 32'hD000_003F, 1'b0, 6'd63, 32'hD000_003F}, // R3 top logical index
    {1'b0, 6'd0,  32'h0,         1'b1, 6'd32, 32'hD000_003F}, // R4 index 31 wraps to 0
    {1'b0, 6'd0,  32'h0,         1'b1, 6'd38, 32'hB000_0002}  // R4 base wrapped below 0
  };

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 predicates cleared", pagg_rd_data, 32'h0);
    chk("R1 predicate bit", {31'b0, pred_rd_bit}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en   = VEC[v][77];
      wr_idx  = VEC[v][76:71];
      wr_data = VEC[v][70:39];
      rotate  = VEC[v][38];
      rd0_idx = VEC[v][37:32];
      rd1_idx = VEC[v][37:32];
      edge_then_idle();
      chk($sformatf("R3/R4 table %0d port0", v), rd0_data, VEC[v][31:0]);
      chk($sformatf("R6 table %0d port1", v), rd1_data, VEC[v][31:0]);
    end

    // R6: old value while the write is pending, new value after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd3; wr_data = 32'hE000_0003;
    rd0_idx = 6'd3; rd1_idx = 6'd3;
    #1;
    chk("R6 read before edge", rd0_data, 32'hA000_0003);
    edge_then_idle();
    chk("R6 read after edge", rd1_data, 32'hE000_0003);

    // R4: 32 rotates bring the name back
    rd0_idx = 6'd38;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      rotate = 1'b1;
      edge_then_idle();
    end
    chk("R4 full ring", rd0_data, 32'hB000_0002);

    // R8 aggregate write and bitwise reads
    @(negedge clk);
    pagg_wr_en = 1'b1; pagg_wr_data = 32'h0000_0005;
    edge_then_idle();
    chk("R8 aggregate read", pagg_rd_data, 32'h0000_0005);
    pred_rd_idx = 5'd2; #1;
    chk("R8 bit 2", {31'b0, pred_rd_bit}, 32'h1);
    pred_rd_idx = 5'd1; #1;
    chk("R8 bit 1", {31'b0, pred_rd_bit}, 32'h0);

    // R7 rotate moves predicates up
    @(negedge clk);
    rotate = 1'b1;
    edge_then_idle();
    chk("R7 rotate", pagg_rd_data, 32'h0000_000A);
    chk("R7 bit 1 took bit 0", {31'b0, pred_rd_bit}, 32'h1);

    // R7 top predicate wraps into predicate 0
    @(negedge clk);
    pagg_wr_en = 1'b1; pagg_wr_data = 32'h8000_0000;
    edge_then_idle();
    @(negedge clk);
    rotate = 1'b1;
    edge_then_idle();
    chk("R7 wrap 31 to 0", pagg_rd_data, 32'h0000_0001);

    // R10 aggregate write in a rotate cycle
    @(negedge clk);
    pagg_wr_en = 1'b1; pagg_wr_data = 32'h0000_0003; rotate = 1'b1;
    edge_then_idle();
    chk("R10 write with rotate", pagg_rd_data, 32'h0000_0006);

    // R9 single bit beats aggregate
    @(negedge clk);
    pagg_wr_en = 1'b1; pagg_wr_data = 32'h0000_00F0;
    pred_wr_en = 1'b1; pred_wr_idx = 5'd4; pred_wr_bit = 1'b0;
    edge_then_idle();
    chk("R9 collision", pagg_rd_data, 32'h0000_00E0);

    // R9 single write in a rotate cycle
    @(negedge clk);
    pred_wr_en = 1'b1; pred_wr_idx = 5'd2; pred_wr_bit = 1'b1; rotate = 1'b1;
    edge_then_idle();
    chk("R9 bit write with rotate", pagg_rd_data, 32'h0000_01C8);
    pred_rd_idx = 5'd3; #1;
    chk("R9 written bit moved to 3", {31'b0, pred_rd_bit}, 32'h1);

    // R1 reset mid-run: bases back to zero, predicates cleared, data kept
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd0_idx = 6'd34; rd1_idx = 6'd3;
    #1;
    chk("R1 predicates after reset", pagg_rd_data, 32'h0);
    chk("R1 base back to zero", rd0_data, 32'hB000_0002);
    chk("R1 static data kept", rd1_data, 32'hE000_0003);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule